// File: doc/BRIEF.md
# Descriptor Ring Serial DMA Engine

This block moves bytes between a serial byte stream and buffers in a data memory. It does not hold the bytes in a FIFO. It follows two rings of buffer descriptors that live in a separate descriptor RAM, one ring for receive and one for transmit. Software owns or hands over each descriptor through a single ownership bit in the descriptor's flag halfword. A wrap bit in the same halfword marks the last descriptor of a ring.

The descriptor RAM is reached through a 16-bit synchronous port with one cycle of read latency. Addresses on that port are byte addresses and are always even. A small parameter area at the start of that RAM holds the ring base offsets:
- offset 0 holds the receive ring base;
- offset 2 holds the transmit ring base.

Each descriptor is 8 bytes long and is stored big-endian:
- offset 0 holds the flag halfword;
- offset 2 holds the length;
- offset 4 holds the high half of the buffer address;
- offset 6 holds the low half of the buffer address.

The data memory port is one byte wide, also has one cycle of read latency, and holds the buffers. Each received byte fills one descriptor and raises a pending event. That event drives the single interrupt line until it is cleared by a write-one-to-clear pulse. Transmit polls the current descriptor and sends its buffer once the ready bit is set.

Top module: `sdma_ring_engine`

## Requirements
- R1: After reset the interrupt line, `rx_ready` and `tx_valid` are low, and both ring indices are 0. The first receive after reset therefore uses the descriptor at the receive ring base.
- R2: For each accepted receive byte, the block does the following:
  - writes the byte to the data memory at the descriptor's 32-bit buffer address;
  - writes 1 into the descriptor length;
  - writes the flag back with bit 15 cleared and every other flag bit unchanged;
  - sets the event bit, which raises `irq`.
- R3: A receive byte is not accepted (`rx_ready` stays low) while `rx_en` is low, while `mask_rx` is low, or while the event bit is pending.
- R4: A one-cycle pulse on `evt_w1c` clears the event bit. `irq` is then low on the next cycle, and the next receive byte is accepted again.
- R5: After the receive engine handles a descriptor, the receive index returns to 0 if flag bit 13 (wrap) was set. Otherwise the index advances by 8.
- R6: While `tx_en` is high and the current transmit descriptor has flag bit 15 (ready) set, the block does the following:
  - sends `length` bytes on `tx_data`, taken in order from consecutive buffer addresses starting at the descriptor's buffer address;
  - then writes the flag back with bit 15 cleared and the other bits unchanged.
- R7: A transmit descriptor with bit 15 clear sends nothing, and the transmit index does not advance. The same descriptor is polled again, and it is sent once its ready bit is set.
- R8: The transmit index follows the same wrap rule as receive: it returns to 0 after a descriptor with flag bit 13 set, and otherwise advances by 8.
- R9: A ready transmit descriptor with length 0 sends no byte but is still released and advanced.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds its value.
- R11: The ring base offsets are read from the parameter halfwords: receive at offset 0 and transmit at offset 2. Descriptor fields use the offsets given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_en | input | 1 | Receive enable |
| tx_en | input | 1 | Transmit enable |
| mask_rx | input | 1 | Receive event mask; receive runs only while this is high |
| evt_w1c | input | 1 | Write-one-to-clear pulse for the receive event bit |
| dr_en | output | 1 | Descriptor RAM access strobe |
| dr_we | output | 1 | Descriptor RAM write |
| dr_addr | output | DR_AW | Descriptor RAM byte address (even) |
| dr_wdata | output | 16 | Descriptor RAM write halfword |
| dr_rdata | input | 16 | Descriptor RAM read halfword, one cycle after the read |
| dm_en | output | 1 | Data memory access strobe |
| dm_we | output | 1 | Data memory write |
| dm_addr | output | DM_AW | Data memory byte address |
| dm_wdata | output | 8 | Data memory write byte |
| dm_rdata | input | 8 | Data memory read byte, one cycle after the read |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte taken this cycle |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit byte taken this cycle |
| irq | output | 1 | Interrupt request; high while the event bit is pending |

## Verification
The bench goes after these corner cases:
- **Wrap descriptor.** A ring that ignored the wrap bit would write the fourth received byte through stale descriptor memory instead of through descriptor 0.
- **Flag write-back.** Other flag bits are randomised around the ownership bit. A write-back that rebuilt the flag from constants would lose those bits.
- **Not-ready transmit descriptor.** A ready descriptor sits right behind a not-ready one. An engine that advanced past the not-ready slot would send the wrong bytes, or send them early.
- **Gated receive and zero-length transmit.** Receive is tried while pending, while masked and while disabled, and a zero-length transmit is sent. Either a byte taken under a gate, or a zero-length descriptor that hangs or emits a byte, shows up at the ports.
- **Back-pressure.** Random `tx_ready` exposes transmit data that changes while it is held.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    localparam int HW_W       = 16;
    localparam int DESC_BYTES = 8;
    localparam int OWN_BIT    = 15;
    localparam int WRAP_BIT   = 13;
    localparam int OFS_LEN    = 2;
    localparam int OFS_AHI    = 4;
    localparam int OFS_ALO    = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RX_PRM,
        ST_RX_FLG,
        ST_RX_AHI,
        ST_RX_PUT,
        ST_RX_REL,
        ST_TX_PRM,
        ST_TX_FLG,
        ST_TX_LEN,
        ST_TX_AHI,
        ST_TX_ALO,
        ST_TX_FET,
        ST_TX_OUT,
        ST_TX_REL
    } state_e;

endpackage

// File: rtl/sdma_ring_ptr.sv
module sdma_ring_ptr #(
    parameter int IDX_W = 16,
    parameter int STEP  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             wrap,
    output logic [IDX_W-1:0] idx
);

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (adv) begin
            idx_d = wrap ? '0 : idx_q + IDX_W'(STEP);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;

    // R7
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(idx));

endmodule

// File: rtl/sdma_evt_bit.sv
module sdma_evt_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    logic evt_d, evt_q;

    always_comb begin
        evt_d = evt_q;
        if (clr) evt_d = 1'b0;
        if (set) evt_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= evt_d;
    end

    assign q = evt_q;

    // R4
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !set |=> !q);

endmodule

// File: rtl/sdma_ring_engine.sv
module sdma_ring_engine
    import sdma_pkg::*;
#(
    parameter int DR_AW    = 16,
    parameter int DM_AW    = 32,
    parameter int PRM_BASE = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             tx_en,
    input  logic             mask_rx,
    input  logic             evt_w1c,
    output logic             dr_en,
    output logic             dr_we,
    output logic [DR_AW-1:0] dr_addr,
    output logic [HW_W-1:0]  dr_wdata,
    input  logic [HW_W-1:0]  dr_rdata,
    output logic             dm_en,
    output logic             dm_we,
    output logic [DM_AW-1:0] dm_addr,
    output logic [7:0]       dm_wdata,
    input  logic [7:0]       dm_rdata,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             rx_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_ready,
    output logic             irq
);

    localparam int NRING = 2;
    localparam logic [DR_AW-1:0] PRM_RX = DR_AW'(PRM_BASE);
    localparam logic [DR_AW-1:0] PRM_TX = DR_AW'(PRM_BASE + 2);
    localparam logic [HW_W-1:0]  OWN_CLR = ~(HW_W'(1) << OWN_BIT);

    typedef struct packed {
        state_e           st;
        logic [DR_AW-1:0] base;
        logic [HW_W-1:0]  flag;
        logic [HW_W-1:0]  len;
        logic [31:0]      bufa;
        logic [HW_W-1:0]  cnt;
        logic [7:0]       txb;
    } core_t;

    core_t cur_q, nxt_d;

    logic [NRING-1:0] adv, wrap;
    logic [DR_AW-1:0] idx [NRING];
    logic             evt_set, evt_pend;

    for (genvar g = 0; g < NRING; g++) begin : g_ring
        sdma_ring_ptr #(.IDX_W(DR_AW), .STEP(DESC_BYTES)) u_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (adv[g]),
            .wrap  (wrap[g]),
            .idx   (idx[g])
        );
    end

    sdma_evt_bit u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (evt_set),
        .clr   (evt_w1c),
        .q     (evt_pend)
    );

    logic [DR_AW-1:0] rx_ptr, tx_ptr;
    logic             rx_go;
    logic [HW_W-1:0]  cnt_inc;

    assign rx_ptr  = cur_q.base + idx[0];
    assign tx_ptr  = cur_q.base + idx[1];
    assign rx_go   = rx_en && mask_rx && !evt_pend && rx_valid;
    assign cnt_inc = cur_q.cnt + HW_W'(1);

    always_comb begin
        nxt_d    = cur_q;
        dr_en    = 1'b0;
        dr_we    = 1'b0;
        dr_addr  = '0;
        dr_wdata = '0;
        dm_en    = 1'b0;
        dm_we    = 1'b0;
        dm_addr  = '0;
        dm_wdata = '0;
        rx_ready = 1'b0;
        tx_valid = 1'b0;
        adv      = '0;
        wrap     = '0;
        evt_set  = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (rx_go) begin
                    dr_en = 1'b1; dr_addr = PRM_RX; nxt_d.st = ST_RX_PRM;
                end else if (tx_en) begin
                    dr_en = 1'b1; dr_addr = PRM_TX; nxt_d.st = ST_TX_PRM;
                end
            end
            ST_RX_PRM: begin
                nxt_d.base = DR_AW'(dr_rdata);
                dr_en = 1'b1; dr_addr = DR_AW'(dr_rdata) + idx[0];
                nxt_d.st = ST_RX_FLG;
            end
            ST_RX_FLG: begin
                nxt_d.flag = dr_rdata;
                dr_en = 1'b1; dr_addr = rx_ptr + DR_AW'(OFS_AHI);
                nxt_d.st = ST_RX_AHI;
            end
            ST_RX_AHI: begin
                nxt_d.bufa[31:16] = dr_rdata;
                dr_en = 1'b1; dr_addr = rx_ptr + DR_AW'(OFS_ALO);
                nxt_d.st = ST_RX_PUT;
            end
            ST_RX_PUT: begin
                rx_ready = 1'b1;
                dm_en = 1'b1; dm_we = 1'b1; dm_wdata = rx_data;
                dm_addr = DM_AW'({cur_q.bufa[31:16], dr_rdata});
                dr_en = 1'b1; dr_we = 1'b1; dr_wdata = HW_W'(1);
                dr_addr = rx_ptr + DR_AW'(OFS_LEN);
                nxt_d.st = ST_RX_REL;
            end
            ST_RX_REL: begin
                dr_en = 1'b1; dr_we = 1'b1; dr_addr = rx_ptr;
                dr_wdata = cur_q.flag & OWN_CLR;
                adv[0] = 1'b1; wrap[0] = cur_q.flag[WRAP_BIT];
                evt_set = 1'b1;
                nxt_d.st = ST_IDLE;
            end
            ST_TX_PRM: begin
                nxt_d.base = DR_AW'(dr_rdata);
                dr_en = 1'b1; dr_addr = DR_AW'(dr_rdata) + idx[1];
                nxt_d.st = ST_TX_FLG;
            end
            ST_TX_FLG: begin
                nxt_d.flag = dr_rdata;
                if (!dr_rdata[OWN_BIT]) begin
                    nxt_d.st = ST_IDLE;
                end else begin
                    dr_en = 1'b1; dr_addr = tx_ptr + DR_AW'(OFS_LEN);
                    nxt_d.st = ST_TX_LEN;
                end
            end
            ST_TX_LEN: begin
                nxt_d.len = dr_rdata;
                dr_en = 1'b1; dr_addr = tx_ptr + DR_AW'(OFS_AHI);
                nxt_d.st = ST_TX_AHI;
            end
            ST_TX_AHI: begin
                nxt_d.bufa[31:16] = dr_rdata;
                dr_en = 1'b1; dr_addr = tx_ptr + DR_AW'(OFS_ALO);
                nxt_d.st = ST_TX_ALO;
            end
            ST_TX_ALO: begin
                nxt_d.bufa[15:0] = dr_rdata;
                nxt_d.cnt = '0;
                if (cur_q.len == '0) begin
                    nxt_d.st = ST_TX_REL;
                end else begin
                    dm_en = 1'b1;
                    dm_addr = DM_AW'({cur_q.bufa[31:16], dr_rdata});
                    nxt_d.st = ST_TX_FET;
                end
            end
            ST_TX_FET: begin
                nxt_d.txb = dm_rdata;
                nxt_d.st = ST_TX_OUT;
            end
            ST_TX_OUT: begin
                tx_valid = 1'b1;
                if (tx_ready) begin
                    nxt_d.cnt = cnt_inc;
                    if (cnt_inc == cur_q.len) begin
                        nxt_d.st = ST_TX_REL;
                    end else begin
                        dm_en = 1'b1;
                        dm_addr = DM_AW'(cur_q.bufa + 32'(cnt_inc));
                        nxt_d.st = ST_TX_FET;
                    end
                end
            end
            ST_TX_REL: begin
                dr_en = 1'b1; dr_we = 1'b1; dr_addr = tx_ptr;
                dr_wdata = cur_q.flag & OWN_CLR;
                adv[1] = 1'b1; wrap[1] = cur_q.flag[WRAP_BIT];
                nxt_d.st = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign tx_data = cur_q.txb;
    assign irq     = evt_pend;

    // R10
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R2
    irq_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(dr_we) && !$past(dr_wdata[OWN_BIT]));

    // R3
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> !irq);

    // R2
    one_byte_per_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |=> !rx_ready);

endmodule

// File: tb/sdma_ring_engine_test.sv
`timescale 1ns/1ps
module sdma_ring_engine_test;

    localparam logic [15:0] RXB = 16'h0100;
    localparam logic [15:0] TXB = 16'h0200;
    localparam int RXN = 3;
    localparam int TXN = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, rx_en, tx_en, mask_rx, evt_w1c;
    logic dr_en, dr_we, dm_en, dm_we;
    logic [15:0] dr_addr, dr_wdata, dr_rdata;
    logic [31:0] dm_addr;
    logic [7:0]  dm_wdata, dm_rdata, rx_data, tx_data;
    logic rx_valid, rx_ready, tx_valid, tx_ready, irq;

    sdma_ring_engine uut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en),
        .mask_rx(mask_rx), .evt_w1c(evt_w1c),
        .dr_en(dr_en), .dr_we(dr_we), .dr_addr(dr_addr),
        .dr_wdata(dr_wdata), .dr_rdata(dr_rdata),
        .dm_en(dm_en), .dm_we(dm_we), .dm_addr(dm_addr),
        .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .irq(irq)
    );

    logic [15:0] drm [1024];
    logic [7:0]  dmm [4096];

    always @(posedge clk) begin
        if (dr_en) begin
            if (dr_we) drm[dr_addr[10:1]] <= dr_wdata;
            else       dr_rdata <= drm[dr_addr[10:1]];
        end
        if (dm_en) begin
            if (dm_we) dmm[dm_addr[11:0]] <= dm_wdata;
            else       dm_rdata <= dmm[dm_addr[11:0]];
        end
    end

    int checks = 0, fails = 0, hold_err = 0, cap_n = 0, exn = 0;
    logic [7:0] cap [256];
    logic [7:0] exq [256];
    bit tx_rand = 0;
    bit prev_hold = 0;
    logic [7:0] prev_data = '0;
    bit done = 0;

    always @(negedge clk) begin
        if (prev_hold && (!tx_valid || tx_data != prev_data)) hold_err++;
        tx_ready = tx_rand ? ($urandom % 4 != 0) : 1'b1;
        if (tx_valid && tx_ready) begin
            cap[cap_n[7:0]] = tx_data;
            cap_n++;
        end
        prev_hold = tx_valid && !tx_ready;
        prev_data = tx_data;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] nidx(input logic [15:0] i, input logic [15:0] fl);
        return fl[13] ? 16'h0 : i + 16'd8;
    endfunction

    function automatic logic [15:0] relflag(input logic [15:0] f);
        return f & 16'h7fff;
    endfunction

    function automatic logic [15:0] hw(input logic [15:0] a);
        return drm[a[10:1]];
    endfunction

    task automatic hw_wr(input logic [15:0] a, input logic [15:0] v);
        drm[a[10:1]] = v;
    endtask

    task automatic rx_send(input logic [7:0] b, input int lim, output bit ok);
        ok = 0;
        @(negedge clk);
        rx_data = b;
        rx_valid = 1'b1;
        for (int i = 0; i < lim; i++) begin
            if (rx_ready) begin ok = 1; break; end
            @(negedge clk);
        end
        if (ok) @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic clr_evt();
        @(negedge clk);
        evt_w1c = 1'b1;
        @(negedge clk);
        evt_w1c = 1'b0;
        chk(irq == 1'b0, "R4 irq low after clear", irq, 0);
    endtask

    logic [15:0] rxi = 16'h0, txi = 16'h0;

    task automatic rx_case(input logic [7:0] b, input bit clear_after);
        logic [15:0] d, fl;
        logic [31:0] ba;
        bit ok;
        d  = RXB + rxi;
        ba = 32'h400 + 32'($urandom % 512);
        fl = 16'h8000 | ((rxi == 16'(8 * (RXN - 1))) ? 16'h2000 : 16'h0) | 16'($urandom % 16);
        hw_wr(d + 16'd4, ba[31:16]);
        hw_wr(d + 16'd6, ba[15:0]);
        hw_wr(d + 16'd2, 16'hffff);
        hw_wr(d, fl);
        rx_send(b, 40, ok);
        chk(ok, "R2 byte accepted", 32'(ok), 1);
        for (int i = 0; i < 20 && !irq; i++) @(negedge clk);
        chk(irq == 1'b1, "R2 irq raised", irq, 1);
        chk(dmm[ba[11:0]] == b, "R2 R5 R11 byte in buffer", dmm[ba[11:0]], b);
        chk(hw(d + 16'd2) == 16'd1, "R2 length is 1", hw(d + 16'd2), 1);
        chk(hw(d) == relflag(fl), "R2 flag released", hw(d), relflag(fl));
        rxi = nidx(rxi, fl);
        if (clear_after) clr_evt();
    endtask

    task automatic tx_fill(input logic [15:0] idx, input int len, input bit rdy, output logic [15:0] fl);
        logic [31:0] ba;
        ba = 32'h800 + 32'(idx) * 32'h8;
        for (int i = 0; i < len; i++) begin
            logic [7:0] v;
            v = 8'($urandom);
            dmm[(ba[11:0] + 12'(i))] = v;
            exq[exn[7:0]] = v;
            exn++;
        end
        fl = (rdy ? 16'h8000 : 16'h0) | ((idx == 16'(8 * (TXN - 1))) ? 16'h2000 : 16'h0) | 16'h0040;
        hw_wr(TXB + idx + 16'd2, 16'(len));
        hw_wr(TXB + idx + 16'd4, ba[31:16]);
        hw_wr(TXB + idx + 16'd6, ba[15:0]);
        hw_wr(TXB + idx, fl);
    endtask

    task automatic wait_rel(input logic [15:0] idx, output bit ok);
        ok = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (!hw(TXB + idx)[15]) begin ok = 1; break; end
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic cmp_cap(input string tag);
        int bad;
        bad = 0;
        for (int i = 0; i < exn; i++) if (cap[i[7:0]] != exq[i[7:0]]) bad++;
        chk(cap_n == exn && bad == 0, tag, cap_n, exn);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        bit ok;
        logic [15:0] fa, fb, t2;
        seed = $urandom(32'h5eed);
        rst_n = 0; rx_en = 0; tx_en = 0; mask_rx = 1; evt_w1c = 0;
        rx_valid = 0; rx_data = '0;
        for (int i = 0; i < 1024; i++) drm[i] = '0;
        for (int i = 0; i < 4096; i++) dmm[i] = '0;
        drm[0] = RXB;
        drm[1] = TXB;
        repeat (3) @(negedge clk);
        rst_n = 1;
        rx_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk(irq == 0, "R1 irq after reset", irq, 0);
        chk(rx_ready == 0, "R1 rx_ready after reset", rx_ready, 0);
        chk(tx_valid == 0, "R1 tx_valid after reset", tx_valid, 0);
        rx_valid = 1'b0;

        // receive path; the first receive uses index 0 (R1)
        rx_en = 1;
        rx_case(8'hC3, 0);
        chk(hw(RXB + 16'd2) == 16'd1, "R1 first rx at ring base", hw(RXB + 16'd2), 1);
        rx_send(8'h5A, 30, ok);
        chk(!ok, "R3 blocked while event pending", 32'(ok), 0);
        clr_evt();
        mask_rx = 0;
        rx_send(8'h5B, 30, ok);
        chk(!ok, "R3 blocked while masked", 32'(ok), 0);
        mask_rx = 1;
        rx_en = 0;
        rx_send(8'h5C, 30, ok);
        chk(!ok, "R3 blocked while disabled", 32'(ok), 0);
        rx_en = 1;
        for (int k = 0; k < 7; k++) rx_case(8'($urandom), 1);
        rx_en = 0;

        // transmit path
        tx_rand = 1;
        tx_en = 1;
        for (int k = 0; k < 7; k++) begin
            cap_n = 0; exn = 0;
            tx_fill(txi, 1 + int'($urandom % 6), 1, fa);
            wait_rel(txi, ok);
            chk(ok && hw(TXB + txi) == relflag(fa), "R6 tx flag released", hw(TXB + txi), relflag(fa));
            cmp_cap("R6 R8 tx bytes in order");
            txi = nidx(txi, fa);
        end

        // zero length (R9)
        cap_n = 0; exn = 0;
        tx_fill(txi, 0, 1, fa);
        wait_rel(txi, ok);
        chk(ok && hw(TXB + txi) == relflag(fa), "R9 zero length released", hw(TXB + txi), relflag(fa));
        chk(cap_n == 0, "R9 zero length sends nothing", cap_n, 0);
        txi = nidx(txi, fa);

        // not ready descriptor is polled in place (R7)
        cap_n = 0; exn = 0;
        tx_fill(txi, 3, 0, fa);
        t2 = nidx(txi, fa);
        tx_fill(t2, 2, 1, fb);
        repeat (60) @(negedge clk);
        chk(cap_n == 0, "R7 nothing sent while not ready", cap_n, 0);
        chk(hw(TXB + t2)[15] == 1'b1, "R7 index not advanced", hw(TXB + t2), fb);
        hw_wr(TXB + txi, fa | 16'h8000);
        wait_rel(txi, ok);
        wait_rel(t2, ok);
        chk(ok, "R7 later descriptor released", hw(TXB + t2), relflag(fb));
        cmp_cap("R7 R8 polled descriptor sent first");
        tx_en = 0;
        repeat (5) @(negedge clk);

        chk(hold_err == 0, "R10 tx data held under back-pressure", hold_err, 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule